// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This unit sits between a register file and a single-port data memory. It carries out one atomic memory operation at a time on a 32-bit or 64-bit location. It accepts a request that carries the following:

- an 8-bit operation selector;
- a size bit;
- a base address and a signed offset;
- the source register value;
- the value of the implicit accumulator register (R0).

It reads the addressed location, computes the new value, writes it back when the operation calls for a write, and then pulses `done`. In the `done` cycle it presents the old memory value for write-back to the source register or to R0.

The request side is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the unit is idle, so a requester holding `req_valid` simply waits. The unit applies no back-pressure on the memory side. Memory read data is expected exactly one cycle after `mem_rd_en`. `mem_lock` tells the memory arbiter to keep other agents away from the read and write cycles of an operation. `done` and the write-back enables are single-cycle pulses with no ready.

Top module: `amo_unit`

## Requirements
- R1: `req_ready` is high only while idle. After a request is taken it stays low until the cycle after `done`.
- R2: The memory address is the base plus the offset. The offset is sign-extended and the sum wraps to the address width. `mem_dword` follows the request's size bit (1 = 64-bit, 0 = 32-bit).
- R3: The read is issued in the cycle after acceptance, and any write in the cycle after the read. `done` is high for one cycle after that. `mem_lock` is high in the read and write cycles and low in the `done` cycle.
- R4: Selector codes 0x00/0x01 add, 0x40/0x41 OR, 0x50/0x51 AND and 0xA0/0xA1 XOR the source into memory. All of them write.
- R5: In 32-bit mode only bits 31:0 of memory and source are used. Arithmetic wraps at 32 bits, and the upper half of `mem_wdata` is zero.
- R6: Selector bit 0 is the fetch flag. On the four simple operations, when it is set, `src_wb_en` pulses with the old memory value (zero-extended in 32-bit mode). When it is clear, no write-back happens.
- R7: Selector 0xE1 (exchange) writes the source value to memory and returns the old value through `src_wb_en`/`src_wb_data`.
- R8: Selector 0xF1 (compare-exchange) writes the source value only when the old value equals R0. In either outcome it returns the zero-extended old value through `r0_wb_en`/`r0_wb_data`, and never writes back to the source.
- R9: A compare-exchange that does not match skips the write cycle but still gives `done` at the normal time. In 32-bit mode the compare looks at bits 31:0 only.
- R10: Any other selector, including 0xE0 and 0xF0, issues the read but no write and no write-back, and still pulses `done`.
- R11: During reset `req_ready` is high, and `mem_rd_en`, `mem_wr_en`, `mem_lock`, `done` and both write-back enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_sel | input | 8 | Operation selector |
| req_dword | input | 1 | 1 = 64-bit, 0 = 32-bit |
| req_base | input | AW (32) | Base address |
| req_offset | input | OFFW (16) | Signed offset |
| req_src | input | DW (64) | Source register value |
| req_r0 | input | DW (64) | R0 value for compare |
| mem_addr | output | AW (32) | Memory address |
| mem_dword | output | 1 | Access size to memory |
| mem_rd_en | output | 1 | Read strobe |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | DW (64) | Write data |
| mem_rdata | input | DW (64) | Read data, one cycle after the read strobe |
| mem_lock | output | 1 | Exclusive-access hold |
| done | output | 1 | Operation finished |
| src_wb_en | output | 1 | Write old value to source register |
| src_wb_data | output | DW (64) | Value for source register |
| r0_wb_en | output | 1 | Write old value to R0 |
| r0_wb_data | output | DW (64) | Value for R0 |

## Verification
Take edge 0 as the edge that accepts a request. The read strobe and address are due right after edge 0, and the write strobe and data right after edge 1. `done` and the write-back values are due right after edge 2, and `req_ready` returns after edge 3. The bench holds a behavioural memory and an expected-value model. It compares every output at the falling edge of each of those four cycles, and in the `done` cycle it also reads back the memory model. That read-back catches a write that should not have happened, or one that damaged the untouched upper half.

// File: rtl/amo_pkg.sv
package amo_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_MODIFY,
    ST_DONE
  } amo_state_e;

  typedef enum logic [2:0] {
    K_ADD,
    K_OR,
    K_AND,
    K_XOR,
    K_XCHG,
    K_CMPX,
    K_BAD
  } amo_kind_e;

  typedef struct packed {
    amo_kind_e kind;
    logic      fetch;
  } amo_dec_t;

  localparam logic [7:0] SEL_XCHG = 8'hE1;
  localparam logic [7:0] SEL_CMPX = 8'hF1;

  // Upper nibble picks the operation, bit 0 is the fetch flag.
  function automatic amo_dec_t amo_decode(input logic [7:0] sel);
    amo_dec_t d;
    d.fetch = sel[0];
    d.kind  = K_BAD;
    if (sel[3:1] == 3'b000) begin
      case (sel[7:4])
        4'h0: d.kind = K_ADD;
        4'h4: d.kind = K_OR;
        4'h5: d.kind = K_AND;
        4'hA: d.kind = K_XOR;
        default: d.kind = K_BAD;
      endcase
    end
    if (sel == SEL_XCHG) d.kind = K_XCHG;
    if (sel == SEL_CMPX) d.kind = K_CMPX;
    return d;
  endfunction

endpackage

// File: rtl/amo_addr_gen.sv
module amo_addr_gen #(
  parameter int AW   = 32,
  parameter int OFFW = 16
) (
  input  logic [AW-1:0]   base,
  input  logic [OFFW-1:0] offset,
  output logic [AW-1:0]   addr
);
  localparam int EXTW = AW - OFFW;

  logic [AW-1:0] off_ext;

  assign off_ext = {{EXTW{offset[OFFW-1]}}, offset};
  assign addr    = base + off_ext;
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DW = 64
) (
  input  amo_kind_e     kind,
  input  logic          dword,
  input  logic [DW-1:0] old_raw,
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] r0,
  output logic [DW-1:0] old_ext,
  output logic          wr_req,
  output logic [DW-1:0] wdata
);
  localparam int WW = DW / 2;

  logic [DW-1:0] src_m, r0_m, result;

  function automatic logic [DW-1:0] low_half(input logic [DW-1:0] x);
    return {{(DW-WW){1'b0}}, x[WW-1:0]};
  endfunction

  assign old_ext = dword ? old_raw : low_half(old_raw);
  assign src_m   = dword ? src     : low_half(src);
  assign r0_m    = dword ? r0      : low_half(r0);

  always_comb begin
    result = '0;
    wr_req = 1'b1;
    case (kind)
      K_ADD:   result = old_ext + src_m;
      K_OR:    result = old_ext | src_m;
      K_AND:   result = old_ext & src_m;
      K_XOR:   result = old_ext ^ src_m;
      K_XCHG:  result = src_m;
      K_CMPX: begin
        result = src_m;
        wr_req = (old_ext == r0_m);
      end
      default: wr_req = 1'b0;
    endcase
  end

  assign wdata = dword ? result : low_half(result);
endmodule

// File: rtl/amo_fsm.sv
module amo_fsm
  import amo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  output amo_state_e state
);
  amo_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:   if (accept) nxt = ST_READ;
      ST_READ:   nxt = ST_MODIFY;
      ST_MODIFY: nxt = ST_DONE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int AW   = 32,
  parameter int OFFW = 16,
  parameter int DW   = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [7:0]      req_sel,
  input  logic            req_dword,
  input  logic [AW-1:0]   req_base,
  input  logic [OFFW-1:0] req_offset,
  input  logic [DW-1:0]   req_src,
  input  logic [DW-1:0]   req_r0,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_dword,
  output logic            mem_rd_en,
  output logic            mem_wr_en,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            mem_lock,
  output logic            done,
  output logic            src_wb_en,
  output logic [DW-1:0]   src_wb_data,
  output logic            r0_wb_en,
  output logic [DW-1:0]   r0_wb_data
);
  amo_state_e    state;
  logic          accept;
  amo_dec_t      dec;
  logic [AW-1:0] addr_c;

  amo_kind_e     kind_q;
  logic          fetch_q, dword_q, sw_q, rw_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] src_q, r0_q, old_q;

  logic [DW-1:0] alu_old, alu_wdata;
  logic          alu_wr;

  assign accept = req_valid && req_ready;
  assign dec    = amo_decode(req_sel);

  amo_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .state  (state)
  );

  amo_addr_gen #(.AW(AW), .OFFW(OFFW)) u_addr (
    .base   (req_base),
    .offset (req_offset),
    .addr   (addr_c)
  );

  amo_alu #(.DW(DW)) u_alu (
    .kind    (kind_q),
    .dword   (dword_q),
    .old_raw (mem_rdata),
    .src     (src_q),
    .r0      (r0_q),
    .old_ext (alu_old),
    .wr_req  (alu_wr),
    .wdata   (alu_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q  <= K_BAD;
      fetch_q <= 1'b0;
      dword_q <= 1'b0;
      addr_q  <= '0;
      src_q   <= '0;
      r0_q    <= '0;
      old_q   <= '0;
      sw_q    <= 1'b0;
      rw_q    <= 1'b0;
    end else begin
      if (accept) begin
        kind_q  <= dec.kind;
        fetch_q <= dec.fetch;
        dword_q <= req_dword;
        addr_q  <= addr_c;
        src_q   <= req_src;
        r0_q    <= req_r0;
      end
      if (state == ST_MODIFY) begin
        old_q <= alu_old;
        sw_q  <= (kind_q == K_XCHG) ||
                 (fetch_q && (kind_q inside {K_ADD, K_OR, K_AND, K_XOR}));
        rw_q  <= (kind_q == K_CMPX);
      end
    end
  end

  assign req_ready   = (state == ST_IDLE);
  assign mem_addr    = addr_q;
  assign mem_dword   = dword_q;
  assign mem_rd_en   = (state == ST_READ);
  assign mem_wr_en   = (state == ST_MODIFY) && alu_wr;
  assign mem_wdata   = (state == ST_MODIFY) ? alu_wdata : '0;
  assign mem_lock    = (state == ST_READ) || (state == ST_MODIFY);
  assign done        = (state == ST_DONE);
  assign src_wb_en   = done && sw_q;
  assign r0_wb_en    = done && rw_q;
  assign src_wb_data = old_q;
  assign r0_wb_data  = old_q;
endmodule

// File: rtl/amo_unit_checker.sv
module amo_unit_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic mem_rd_en,
  input logic mem_wr_en,
  input logic mem_lock,
  input logic done,
  input logic src_wb_en,
  input logic r0_wb_en
);
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r3_read_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> mem_rd_en);

  a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(mem_rd_en));

  a_r3_done_two_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_rd_en, 2));

  a_r3_lock_on_access: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || mem_wr_en) |-> mem_lock);

  a_r3_unlock_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_lock);

  a_r10_wb_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    (src_wb_en || r0_wb_en) |-> done);

  a_r8_single_wb_target: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_wb_en && r0_wb_en));
endmodule

bind amo_unit amo_unit_checker u_amo_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .mem_rd_en (mem_rd_en),
  .mem_wr_en (mem_wr_en),
  .mem_lock  (mem_lock),
  .done      (done),
  .src_wb_en (src_wb_en),
  .r0_wb_en  (r0_wb_en)
);

// File: tb/amo_unit_bench.sv
module amo_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_sel = '0;
  logic        req_dword = 1'b0;
  logic [31:0] req_base = '0;
  logic [15:0] req_offset = '0;
  logic [63:0] req_src = '0;
  logic [63:0] req_r0 = '0;
  logic [31:0] mem_addr;
  logic        mem_dword, mem_rd_en, mem_wr_en, mem_lock, done;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata = '0;
  logic        src_wb_en, r0_wb_en;
  logic [63:0] src_wb_data, r0_wb_data;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [63:0] mem [int unsigned];

  always #5 clk = ~clk;

  amo_unit u_amo_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_dword(req_dword), .req_base(req_base),
    .req_offset(req_offset), .req_src(req_src), .req_r0(req_r0),
    .mem_addr(mem_addr), .mem_dword(mem_dword), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_lock(mem_lock), .done(done), .src_wb_en(src_wb_en),
    .src_wb_data(src_wb_data), .r0_wb_en(r0_wb_en), .r0_wb_data(r0_wb_data)
  );

  // Behavioural memory: read data one cycle after the strobe.
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
    if (mem_wr_en) begin
      logic [63:0] cur;
      cur = mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
      if (mem_dword) mem[mem_addr] = mem_wdata;
      else           mem[mem_addr] = {cur[63:32], mem_wdata[31:0]};
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] peek(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  task automatic run_op(input string req, input logic [7:0] sel, input bit dw,
                        input logic [31:0] base, input logic [15:0] off,
                        input logic [63:0] src, input logic [63:0] r0);
    logic [31:0] a;
    logic [63:0] m, old, s, r, nv, wd, mem_after;
    bit wr, swb, rwb;
    a   = base + {{16{off[15]}}, off};
    m   = peek(a);
    old = dw ? m   : {32'h0, m[31:0]};
    s   = dw ? src : {32'h0, src[31:0]};
    r   = dw ? r0  : {32'h0, r0[31:0]};
    wr  = 1; nv = 0;
    case (sel)
      8'h00, 8'h01: nv = old + s;
      8'h40, 8'h41: nv = old | s;
      8'h50, 8'h51: nv = old & s;
      8'hA0, 8'hA1: nv = old ^ s;
      8'hE1:        nv = s;
      8'hF1: begin nv = s; wr = (old == r); end
      default:      wr = 0;
    endcase
    wd  = dw ? nv : {32'h0, nv[31:0]};
    swb = (sel inside {8'h01, 8'h41, 8'h51, 8'hA1, 8'hE1});
    rwb = (sel == 8'hF1);
    mem_after = !wr ? m : (dw ? wd : {m[63:32], wd[31:0]});

    @(negedge clk);
    chk(req_ready == 1'b1, "R1", {req, " ready idle"}, req_ready, 1);
    req_valid = 1; req_sel = sel; req_dword = dw; req_base = base;
    req_offset = off; req_src = src; req_r0 = r0;
    @(negedge clk);  // read cycle
    req_valid = 0;
    chk(req_ready == 1'b0, "R1", {req, " ready busy"}, req_ready, 0);
    chk(mem_rd_en && mem_lock && !mem_wr_en && !done, "R3",
        {req, " read cycle strobes"}, {mem_rd_en, mem_lock, mem_wr_en, done}, 4'b1100);
    chk(mem_addr == a, "R2", {req, " address"}, mem_addr, a);
    chk(mem_dword == dw, "R2", {req, " size"}, mem_dword, dw);
    @(negedge clk);  // modify cycle
    chk(mem_wr_en == wr, wr ? "R4" : "R9", {req, " write strobe"}, mem_wr_en, wr);
    chk(mem_lock && !mem_rd_en && !done, "R3", {req, " modify strobes"},
        {mem_lock, mem_rd_en, done}, 3'b100);
    if (wr) chk(mem_wdata == wd, dw ? "R4" : "R5", {req, " write data"}, mem_wdata, wd);
    @(negedge clk);  // done cycle
    chk(done && !mem_lock && !mem_wr_en && !mem_rd_en, "R3", {req, " done cycle"},
        {done, mem_lock, mem_wr_en, mem_rd_en}, 4'b1000);
    chk(src_wb_en == swb, "R6", {req, " src write-back enable"}, src_wb_en, swb);
    chk(r0_wb_en == rwb, "R8", {req, " r0 write-back enable"}, r0_wb_en, rwb);
    if (swb) chk(src_wb_data == old, "R7", {req, " src value"}, src_wb_data, old);
    if (rwb) chk(r0_wb_data == old, "R8", {req, " r0 value"}, r0_wb_data, old);
    chk(peek(a) == mem_after, "R10", {req, " memory after"}, peek(a), mem_after);
    @(negedge clk);
    chk(req_ready && !done, "R1", {req, " ready again"}, {req_ready, done}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_rd_en && !mem_wr_en && !mem_lock && !done &&
        !src_wb_en && !r0_wb_en, "R11", "reset state",
        {req_ready, mem_rd_en, mem_wr_en, mem_lock, done, src_wb_en, r0_wb_en}, 7'b1000000);
    rst_n = 1;
    mem[32'h100] = 64'h0000_0001_FFFF_FFFF;
    mem[32'h108] = 64'hAAAA_5555_F0F0_0F0F;
    mem[32'h0FF8] = 64'h1234_5678_9ABC_DEF0;
    mem[32'h200] = 64'h0000_0000_0000_0042;
    mem[32'h208] = 64'hDEAD_BEEF_0000_0007;

    run_op("R4 add dword",        8'h00, 1, 32'h100, 16'h0, 64'h1, 0);
    run_op("R5 add word wrap",    8'h01, 0, 32'h108, 16'h0, 64'hFFFF_FFFF_F0F0_F0F1, 0);
    run_op("R2 or negative off",  8'h41, 1, 32'h1000, 16'hFFF8, 64'hFF, 0);
    run_op("R6 and no fetch",     8'h50, 1, 32'h100, 16'h0, 64'h0000_0000_FFFF_0000, 0);
    run_op("R6 xor fetch word",   8'hA1, 0, 32'h100, 16'h8, 64'h1111_1111_1234_5678, 0);
    run_op("R7 xchg dword",       8'hE1, 1, 32'h200, 16'h0, 64'hCAFE_0000_0000_BABE, 0);
    run_op("R7 xchg word",        8'hE1, 0, 32'h208, 16'h0, 64'h9999_9999_0000_0055, 0);
    run_op("R8 cmpx equal",       8'hF1, 1, 32'h200, 16'h0, 64'h5, 64'hCAFE_0000_0000_BABE);
    run_op("R9 cmpx mismatch",    8'hF1, 1, 32'h200, 16'h0, 64'h6, 64'h4);
    run_op("R9 cmpx word low eq", 8'hF1, 0, 32'h208, 16'h0, 64'h77, 64'hFFFF_0000_0000_0055);
    run_op("R10 sel e0",          8'hE0, 1, 32'h200, 16'h0, 64'h9, 0);
    run_op("R10 sel f0",          8'hF0, 1, 32'h200, 16'h0, 64'h9, 64'h5);
    run_op("R10 sel 10",          8'h10, 0, 32'h100, 16'h0, 64'h9, 0);
    run_op("R4 xor dword",        8'hA0, 1, 32'h0FF8, 16'h0, 64'hFFFF_0000_FFFF_0000, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule